// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block gathers single-cycle interrupt events from the pins of several 8-pin GPIO ports. It folds them into a small number of group interrupt lines. Each group covers up to four consecutive ports, and each of those ports owns one byte of the group's 32-bit word. Each group keeps three registers:

- a sticky pending word, which software clears by writing ones;
- an enable word, which has one address that only sets bits and another that only clears bits;
- a read-only masked view of pending AND enable.

One block-enable word, indexed by group number, decides which groups may drive their output lines.

Software reaches the registers through a plain word-addressed read/write port with one cycle of read latency. Each group line is a registered level. It stays high while the group's block-enable bit is set and its masked word is nonzero. Software services a line by reading the masked word and writing the same value back to the pending address.

Top module: `gpio_irq_aggr`

## Requirements
- R1: Ports map to group indices 0..4 as follows: ports 0..3 to index 0, ports 4..7 to index 1, ports 10..13 to index 2, ports 14..17 to index 3, and ports 20..21 to index 4. A pulse on pin_evt bit p*8+i (port p, pin i) sets pending bit (p - first port of the group)*8 + i of that group. Ports 8, 9, 18 and 19 belong to no group, and their events change nothing.
- R2: Pending bits are sticky. Writing to address 4k+0 clears every pending bit of group index k whose data bit is 1, whatever that bit's enable. Bits written as 0 keep their value.
- R3: If a clearing write and an event reach the same pending bit in the same cycle, the bit ends up set.
- R4: Writing to address 4k+1 sets every enable bit of group index k whose data bit is 1. Bits written as 0 keep their value.
- R5: Writing to address 4k+2 clears every enable bit of group index k whose data bit is 1. Bits written as 0 keep their value. Reads at 4k+1 and 4k+2 both return the enable word.
- R6: Address 4k+3 reads as pending AND enable of group index k. Writes to it change nothing.
- R7: Address 20 holds the 32-bit block-enable word, written whole. Group indices 0, 1, 2, 3 and 4 are gated by its bits 11, 10, 9, 8 and 20 respectively.
- R8: On the clock edge after the one where the condition holds, irq_out[k] goes high. The condition is that the block-enable bit of group index k is set and that group's masked word is nonzero. Otherwise irq_out[k] is low on that edge.
- R9: After reset every register reads as zero and every irq_out bit is low.
- R10: When reg_rd is high at an edge, reg_rdata shows after that edge the addressed value as it was before the edge. Addresses 21..31 read as zero. reg_rdata holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_evt | input | NUM_PORTS*PINS_PER_PORT (176) | One-cycle event pulses, bit p*8+i for port p pin i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (5) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_GROUPS (5) | Registered level interrupt line per group index |

## Verification
The bench builds the block with its default parameters: 22 ports of 8 pins and five groups, based at ports 0, 4, 10, 14 and 20, with group numbers 11, 10, 9, 8 and 20. This setting has gaps between the groups (ports 8, 9, 18 and 19), so events that must be ignored can be tested. It also has a short last group that holds only two ports, so its upper slots are empty. The group numbers are not in the same order as the group indices, so a block-enable bit that reaches the wrong line shows up at once. A behavioural model of the pending, enable and block-enable words is compared with irq_out on every clock and with every read. Directed sequences cover clear-versus-event collisions, set/clear independence, writes to the read-only address and unmapped reads. A random phase follows them.

// File: rtl/gia_pkg.sv
package gia_pkg;
  // Per-group register slot, selected by the low two address bits
  typedef enum logic [1:0] {
    SLOT_PEND  = 2'd0,
    SLOT_ENSET = 2'd1,
    SLOT_ENCLR = 2'd2,
    SLOT_MASK  = 2'd3
  } gia_slot_e;

  localparam int SLOTS_PER_GROUP = 4;
endpackage

// File: rtl/gia_route.sv
module gia_route #(
  parameter int NUM_PORTS       = 22,
  parameter int PINS_PER_PORT   = 8,
  parameter int NUM_GROUPS      = 5,
  parameter int PORTS_PER_GROUP = 4,
  parameter logic [NUM_GROUPS-1:0][7:0] GRP_BASE = {8'd20, 8'd14, 8'd10, 8'd4, 8'd0},
  localparam int GRP_W = PORTS_PER_GROUP * PINS_PER_PORT
) (
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_evt,
  output logic [NUM_GROUPS-1:0][GRP_W-1:0]   grp_evt
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar s = 0; s < PORTS_PER_GROUP; s++) begin : g_slot
      localparam int PORT = int'(GRP_BASE[g]) + s;
      if (PORT < NUM_PORTS) begin : g_live
        assign grp_evt[g][s*PINS_PER_PORT +: PINS_PER_PORT] =
          pin_evt[PORT*PINS_PER_PORT +: PINS_PER_PORT];
      end else begin : g_empty
        assign grp_evt[g][s*PINS_PER_PORT +: PINS_PER_PORT] = '0;
      end
    end
  end
endmodule

// File: rtl/gia_group.sv
module gia_group #(
  parameter int GRP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] evt,
  input  logic [GRP_W-1:0] pend_clr,
  input  logic [GRP_W-1:0] en_set,
  input  logic [GRP_W-1:0] en_clr,
  output logic [GRP_W-1:0] pend_q,
  output logic [GRP_W-1:0] en_q,
  output logic [GRP_W-1:0] masked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // a fresh event overrides a clear of the same bit
      pend_q <= (pend_q & ~pend_clr) | evt;
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  assign masked = pend_q & en_q;

  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));
  // R2
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_clr & ~evt) != '0) |=> ((pend_q & $past(pend_clr & ~evt)) == '0));
  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en_set != '0) |=> ((en_q & $past(en_set)) == $past(en_set)));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (en_set == '0 && en_clr == '0) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/gia_gate.sv
module gia_gate #(
  parameter int NUM_GROUPS = 5,
  parameter int DATA_W     = 32,
  parameter logic [NUM_GROUPS-1:0][7:0] GRP_ID = {8'd20, 8'd8, 8'd9, 8'd10, 8'd11}
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              blk_wr,
  input  logic [DATA_W-1:0]                 blk_wdata,
  input  logic [NUM_GROUPS-1:0][DATA_W-1:0] grp_masked,
  output logic [DATA_W-1:0]                 blk_q,
  output logic [NUM_GROUPS-1:0]             irq_q
);
  always_ff @(posedge clk) begin
    if (rst)         blk_q <= '0;
    else if (blk_wr) blk_q <= blk_wdata;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_line
    localparam int BIT = int'(GRP_ID[g]);
    logic want;
    assign want = blk_q[BIT] && (grp_masked[g] != '0);

    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= want;
    end

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_q[g] == $past(blk_q[BIT] && (grp_masked[g] != '0))));
  end
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr #(
  parameter int NUM_PORTS       = 22,
  parameter int PINS_PER_PORT   = 8,
  parameter int NUM_GROUPS      = 5,
  parameter int PORTS_PER_GROUP = 4,
  parameter int ADDR_W          = 5,
  parameter logic [NUM_GROUPS-1:0][7:0] GRP_BASE = {8'd20, 8'd14, 8'd10, 8'd4, 8'd0},
  parameter logic [NUM_GROUPS-1:0][7:0] GRP_ID   = {8'd20, 8'd8, 8'd9, 8'd10, 8'd11},
  localparam int DATA_W = PORTS_PER_GROUP * PINS_PER_PORT
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_evt,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  output logic [NUM_GROUPS-1:0]             irq_out
);
  import gia_pkg::*;

  localparam int BLK_ADDR = NUM_GROUPS * SLOTS_PER_GROUP;
  localparam int GSEL_W   = ADDR_W - 2;

  logic [NUM_GROUPS-1:0][DATA_W-1:0] grp_evt;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] pend_clr, en_set, en_clr;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] pend_q, en_q, masked;
  logic [DATA_W-1:0]                 blk_q;
  logic [DATA_W-1:0]                 rd_val;
  logic [GSEL_W-1:0]                 addr_grp;
  gia_slot_e                         addr_slot;
  logic                              in_grp;
  logic                              blk_hit;

  assign addr_grp  = reg_addr[ADDR_W-1:2];
  assign addr_slot = gia_slot_e'(reg_addr[1:0]);
  assign in_grp    = reg_addr < ADDR_W'(BLK_ADDR);
  assign blk_hit   = reg_addr == ADDR_W'(BLK_ADDR);

  gia_route #(
    .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT),
    .NUM_GROUPS(NUM_GROUPS), .PORTS_PER_GROUP(PORTS_PER_GROUP),
    .GRP_BASE(GRP_BASE)
  ) u_route (
    .pin_evt(pin_evt),
    .grp_evt(grp_evt)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_wr && in_grp && (int'(addr_grp) == g);
    assign pend_clr[g] = (hit && addr_slot == SLOT_PEND)  ? reg_wdata : '0;
    assign en_set[g]   = (hit && addr_slot == SLOT_ENSET) ? reg_wdata : '0;
    assign en_clr[g]   = (hit && addr_slot == SLOT_ENCLR) ? reg_wdata : '0;

    gia_group #(.GRP_W(DATA_W)) u_grp (
      .clk(clk), .rst(rst),
      .evt(grp_evt[g]),
      .pend_clr(pend_clr[g]),
      .en_set(en_set[g]),
      .en_clr(en_clr[g]),
      .pend_q(pend_q[g]),
      .en_q(en_q[g]),
      .masked(masked[g])
    );
  end

  gia_gate #(
    .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .GRP_ID(GRP_ID)
  ) u_gate (
    .clk(clk), .rst(rst),
    .blk_wr(reg_wr && blk_hit),
    .blk_wdata(reg_wdata),
    .grp_masked(masked),
    .blk_q(blk_q),
    .irq_q(irq_out)
  );

  always_comb begin
    rd_val = '0;
    if (blk_hit) rd_val = blk_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (in_grp && int'(addr_grp) == g) begin
        unique case (addr_slot)
          SLOT_PEND:              rd_val = pend_q[g];
          SLOT_ENSET, SLOT_ENCLR: rd_val = en_q[g];
          SLOT_MASK:              rd_val = masked[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr > ADDR_W'(BLK_ADDR)) |=> (reg_rdata == '0));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  // R7
  blk_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && blk_hit) |=> (blk_q == $past(reg_wdata)));
endmodule

// File: tb/sim_gpio_irq_aggr.sv
`timescale 1ns/1ps
module sim_gpio_irq_aggr;
  localparam int NP = 22;
  localparam int EW = NP * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [EW-1:0] pin_evt = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [4:0]    irq_out;

  gpio_irq_aggr u0 (
    .clk(clk), .rst(rst), .pin_evt(pin_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  int base_of[5] = '{0, 4, 10, 14, 20};
  int id_of[5]   = '{11, 10, 9, 8, 20};

  logic [31:0] m_pend[5];
  logic [31:0] m_en[5];
  logic [31:0] m_blk;
  logic [4:0]  m_irq;
  logic [31:0] m_rdata;
  bit          m_valid = 0;
  bit          rd_pend = 0;
  string       cur_tag = "R9";
  string       rd_tag  = "R9";
  int          n_chk = 0;
  int          n_bad = 0;

  function automatic int group_of(int p);
    for (int g = 0; g < 5; g++)
      if (p >= base_of[g] && p < base_of[g] + 4) return g;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    int g;
    if (a < 20) begin
      g = int'(a) / 4;
      case (int'(a) % 4)
        0:       return m_pend[g];
        1, 2:    return m_en[g];
        default: return m_pend[g] & m_en[g];
      endcase
    end
    if (a == 20) return m_blk;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 5; g++) begin m_pend[g] = '0; m_en[g] = '0; end
      m_blk = '0; m_irq = '0; m_rdata = '0; rd_pend = 0; m_valid = 1;
    end else begin
      logic [31:0] ev[5];
      rd_pend = reg_rd;
      rd_tag  = cur_tag;
      if (reg_rd) m_rdata = m_read(reg_addr);
      for (int g = 0; g < 5; g++)
        m_irq[g] = m_blk[id_of[g]] && ((m_pend[g] & m_en[g]) != 0);
      for (int g = 0; g < 5; g++) ev[g] = '0;
      for (int p = 0; p < NP; p++) begin
        int g;
        g = group_of(p);
        if (g >= 0) ev[g][(p - base_of[g])*8 +: 8] = pin_evt[p*8 +: 8];
      end
      if (reg_wr) begin
        if (reg_addr < 20) begin
          int g;
          g = int'(reg_addr) / 4;
          case (int'(reg_addr) % 4)
            0: m_pend[g] = m_pend[g] & ~reg_wdata;
            1: m_en[g]   = m_en[g] | reg_wdata;
            2: m_en[g]   = m_en[g] & ~reg_wdata;
            default: ;
          endcase
        end else if (reg_addr == 20) m_blk = reg_wdata;
      end
      for (int g = 0; g < 5; g++) m_pend[g] = m_pend[g] | ev[g];
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8 compared every cycle; reads compared against the model
  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk({27'h0, irq_out}, {27'h0, m_irq}, "R8 irq_out");
      if (rd_pend) chk(reg_rdata, m_rdata, rd_tag);
    end
  end

  function automatic logic [EW-1:0] ev1(int port, int pin);
    logic [EW-1:0] e;
    e = '0;
    e[port*8 + pin] = 1'b1;
    return e;
  endfunction

  task automatic step(input logic w, input logic r, input logic [4:0] a,
                      input logic [31:0] d, input logic [EW-1:0] e, input string tag);
    @(negedge clk);
    cur_tag = tag; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; pin_evt = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 5'd0, 32'h0, '0, cur_tag);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(0, 1, a, 32'h0, '0, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state, literal check plus model reads
    chk({27'h0, irq_out}, 32'h0, "R9 irq after reset");
    for (int a = 0; a < 21; a++) rd(5'(a), "R9 reset read");
    idle(1);
    chk(reg_rdata, 32'h0, "R9 reset blk");

    // R1 event routing including unmapped ports 8, 9, 18, 19
    step(0, 0, 0, 0, ev1(0, 3) | ev1(5, 7) | ev1(13, 0) | ev1(21, 6), "R1");
    step(0, 0, 0, 0, ev1(8, 1) | ev1(9, 4) | ev1(18, 2) | ev1(19, 7), "R1");
    for (int g = 0; g < 5; g++) rd(5'(g*4), "R1 pending");
    idle(1);
    chk(reg_rdata, 32'h0000_4000, "R1 group4 literal");

    // R2 clear works with enable off; zero bits leave others
    step(0, 0, 0, 0, ev1(1, 2), "R2");
    step(1, 0, 5'd0, 32'h0000_0008, '0, "R2");
    rd(5'd0, "R2 pending after clear");
    step(1, 0, 5'd0, 32'h0, '0, "R2");
    rd(5'd0, "R2 zero write");
    idle(1);
    chk(reg_rdata, 32'h0000_0400, "R2 literal");

    // R4 / R5 enable set and clear
    step(1, 0, 5'd1, 32'h0000_00FF, '0, "R4");
    step(1, 0, 5'd1, 32'h0000_0400, '0, "R4");
    rd(5'd1, "R4 enable via set addr");
    step(1, 0, 5'd2, 32'h0000_000F, '0, "R5");
    rd(5'd2, "R5 enable via clr addr");
    step(1, 0, 5'd2, 32'h0, '0, "R5");
    rd(5'd1, "R5 zero clear");
    idle(1);
    chk(reg_rdata, 32'h0000_04F0, "R5 literal");

    // R6 masked view, writes ignored
    rd(5'd3, "R6 masked");
    step(1, 0, 5'd3, 32'hFFFF_FFFF, '0, "R6");
    rd(5'd3, "R6 after write");
    rd(5'd0, "R6 pending untouched");

    // R7 / R8 block enable gating per group number
    step(1, 0, 5'd20, 32'h0000_0400, '0, "R7");
    idle(3);
    step(1, 0, 5'd20, 32'h0000_0800, '0, "R7");
    idle(3);
    chk({27'h0, irq_out}, 32'h1, "R8 group0 line");
    step(1, 0, 5'd21, 32'h0010_0000, ev1(21, 6), "R7");
    step(1, 0, 5'd17, 32'h0000_4000, '0, "R7");
    step(1, 0, 5'd20, 32'h0010_0800, '0, "R7");
    rd(5'd20, "R7 blk");
    idle(3);
    chk({27'h0, irq_out}, 32'h11, "R8 group4 line");
    step(1, 0, 5'd0, 32'h0000_0400, '0, "R8");
    idle(3);

    // R3 collision: event wins
    step(1, 0, 5'd0, 32'h0000_0002, ev1(0, 1), "R3");
    rd(5'd0, "R3 collision");
    idle(1);
    chk(reg_rdata & 32'h2, 32'h2, "R3 literal");

    // R10 unmapped reads, read-before-write, hold
    rd(5'd25, "R10 unmapped");
    rd(5'd31, "R10 unmapped");
    step(1, 1, 5'd1, 32'hFFFF_0000, '0, "R10 same-edge read");
    idle(3);
    chk(reg_rdata, m_rdata, "R10 hold");

    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      logic [EW-1:0] e;
      logic [4:0] a;
      logic [31:0] d;
      e = '0;
      if ($urandom_range(0, 2) == 0) e[$urandom_range(0, EW-1)] = 1'b1;
      if ($urandom_range(0, 4) == 0) e[$urandom_range(0, EW-1)] = 1'b1;
      a = 5'($urandom_range(0, 23));
      d = $urandom;
      if (a == 20) d = d & 32'h0010_0F00;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, a, d, e, "mixed");
    end
    idle(4);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule